// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the acknowledge and end-of-interrupt engine of one processor's interrupt interface. It holds the interrupt currently being serviced (the running ID) together with its running priority, and a nesting record that links every active interrupt to the one it pre-empted. Highest-pending selection, priority storage and register decoding live elsewhere. The block receives the highest-pending ID, the per-source priorities and the per-source configuration and line state. It answers acknowledge requests and emits pending-clear and pending-set pulses for the pending store.

An acknowledge returns the highest-pending ID when that interrupt strictly beats the running priority. In that case the block also clears its pending state and pushes it on the nesting record. Otherwise the acknowledge returns the idle code 1023 and nothing changes. An end-of-interrupt write names an interrupt to retire. When it names the running interrupt, the previous one is restored in the same cycle. When it names an interrupt deeper in the nesting, a small walker follows the links one per cycle and unlinks it, leaving the running interrupt untouched. While the walker runs, the block reports busy and drops any new request.

Top module: `irq_ack_tracker`

## Requirements
- R1: An acknowledge returns 1023 and leaves the running ID and running priority unchanged when the highest-pending ID is 1023 or not below NUM_SRC, or when its 8-bit priority is not strictly below the 9-bit running priority (equal priority is refused).
- R2: A granted acknowledge returns the highest-pending ID one cycle after the request. That ID becomes the running ID, with its own priority as running priority. The previous running ID is recorded as its predecessor.
- R3: After reset, and whenever the running ID is 1023, the running priority is 0x100, so any 8-bit priority, 0xFF included, is granted from idle.
- R4: A granted acknowledge raises `clr_valid` for one cycle with `clr_id` equal to the granted ID. `clr_all` is 1 when `src_one_of_n` bit of that ID is set (clear for all processors) and 0 otherwise (clear for this processor only).
- R5: An end-of-interrupt whose ID is at or above NUM_SRC (1023 included), or that arrives while the running ID is 1023, changes no state and raises no pending-set pulse.
- R6: An end-of-interrupt naming the running ID makes its recorded predecessor the running ID in the same cycle, with that predecessor's priority, or 0x100 when the predecessor is 1023.
- R7: An end-of-interrupt naming an interrupt other than the running one leaves the running ID unchanged. It removes the named interrupt from the nesting chain, so a later completion of its successor restores the named interrupt's own predecessor.
- R8: On an accepted end-of-interrupt, `set_valid` pulses with `set_id` equal to the completed ID when that source is level-sensitive (`src_level` bit 1), enabled, its line is high and this processor is in its target set. An edge-triggered source gets no pulse.
- R9: The end-of-interrupt ID is bits 9:0 of `eoi_data`; bits 31:10 are ignored.
- R10: The chain walk examines one link per cycle: `busy` stays high for as many cycles as links read before the match (or before reaching 1023). Acknowledge and end-of-interrupt requests presented while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request, one cycle |
| hp_id | input | 10 | Highest-pending interrupt ID (1023 when none) |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | End-of-interrupt write value |
| prio_flat | input | NUM_SRC*8 | Priority of source i in bits 8i+7:8i, lower is more urgent |
| src_enable | input | NUM_SRC | Source enabled |
| src_level | input | NUM_SRC | 1 = level-sensitive, 0 = edge-triggered |
| src_line | input | NUM_SRC | Current input line state |
| src_target | input | NUM_SRC | This processor is in the source's target set |
| src_one_of_n | input | NUM_SRC | Source uses the 1-of-N model |
| clr_valid | output | 1 | Pending-clear pulse |
| clr_id | output | 10 | ID whose pending state is cleared |
| clr_all | output | 1 | Clear applies to all processors |
| set_valid | output | 1 | Pending-set pulse for this processor |
| set_id | output | 10 | ID set pending again |
| running_id | output | 10 | Running interrupt ID (1023 when idle) |
| running_prio | output | 9 | Running priority (0x100 when idle) |
| busy | output | 1 | Chain walk in progress |

## Verification
The bench builds a four-deep nesting and then retires interrupts out of order. It removes the direct predecessor of the running interrupt (one walk cycle) and the deepest entry (three walk cycles), and asks for an ID absent from the chain. A design that rewired the wrong link would restore a retired interrupt on a later completion. A design that touched the running ID during a walk would change the reported priority. The equal-priority acknowledge and the 0xFF-from-idle acknowledge target an off-by-one in the strict comparison. An acknowledge during the walk and a completion while idle on a high level source catch a design that ignores `busy` or re-pends without an active interrupt.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;

  typedef logic [ID_W-1:0]   irq_id_t;
  typedef logic [PRIO_W:0]   run_prio_t;
  typedef logic [PRIO_W-1:0] src_prio_t;

  localparam irq_id_t   NO_IRQ    = 10'h3FF;
  localparam run_prio_t IDLE_PRIO = 9'h100;

  typedef enum logic {WK_IDLE, WK_SCAN} walk_state_t;

  // ID is a real, implemented source
  function automatic logic id_in_range(input irq_id_t id, input int unsigned nsrc);
    return 32'(id) < nsrc;
  endfunction

  // strict comparison: lower value is more urgent, equal does not pre-empt
  function automatic logic can_preempt(input src_prio_t cand, input run_prio_t run);
    return {1'b0, cand} < run;
  endfunction

  // completion ID field of the written word
  function automatic irq_id_t eoi_field(input logic [31:0] word);
    return word[ID_W-1:0];
  endfunction
endpackage

// File: rtl/irq_ack_link_mem.sv
module irq_ack_link_mem
  import irq_ack_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned NRD   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  irq_id_t                  waddr,
  input  irq_id_t                  wdata,
  input  logic [NRD-1:0][ID_W-1:0] raddr,
  output logic [NRD-1:0][ID_W-1:0] rdata
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  irq_id_t links [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) links[i] <= NO_IRQ;
    end else if (we && id_in_range(waddr, DEPTH)) begin
      links[waddr[AW-1:0]] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = id_in_range(raddr[p], DEPTH) ? links[raddr[p][AW-1:0]] : NO_IRQ;
  end
endmodule

// File: rtl/irq_ack_walker.sv
module irq_ack_walker
  import irq_ack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  irq_id_t start_id,
  input  irq_id_t victim_id,
  output irq_id_t cur_id,
  output irq_id_t tgt_id,
  input  irq_id_t cur_link,
  input  irq_id_t tgt_link,
  output logic    wr_en,
  output irq_id_t wr_addr,
  output irq_id_t wr_data,
  output logic    busy,
  output logic    walk_hit,
  output logic    walk_end
);
  walk_state_t st;
  irq_id_t     cur_q, tgt_q;
  logic        scanning;

  assign scanning = (st == WK_SCAN);
  assign walk_hit = scanning && (cur_link == tgt_q) && (cur_link != NO_IRQ);
  assign walk_end = scanning && (cur_link == NO_IRQ);
  assign busy     = scanning;
  assign cur_id   = cur_q;
  assign tgt_id   = tgt_q;
  assign wr_en    = walk_hit;
  assign wr_addr  = cur_q;
  assign wr_data  = tgt_link;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WK_IDLE;
      cur_q <= NO_IRQ;
      tgt_q <= NO_IRQ;
    end else if (!scanning) begin
      if (start) begin
        st    <= WK_SCAN;
        cur_q <= start_id;
        tgt_q <= victim_id;
      end
    end else if (walk_hit || walk_end) begin
      st <= WK_IDLE;
    end else begin
      cur_q <= cur_link;
    end
  end
endmodule

// File: rtl/irq_ack_repend.sv
module irq_ack_repend
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  irq_id_t              id,
  input  logic [NUM_SRC-1:0]   src_enable,
  input  logic [NUM_SRC-1:0]   src_level,
  input  logic [NUM_SRC-1:0]   src_line,
  input  logic [NUM_SRC-1:0]   src_target,
  output logic                 repend
);
  localparam int unsigned AW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  always_comb begin
    repend = 1'b0;
    if (id_in_range(id, NUM_SRC)) begin
      repend = src_level[id[AW-1:0]] && src_enable[id[AW-1:0]] &&
               src_line[id[AW-1:0]]  && src_target[id[AW-1:0]];
    end
  end
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_req,
  input  logic [9:0]             hp_id,
  output logic                   ack_valid,
  output logic [9:0]             ack_id,
  input  logic                   eoi_req,
  input  logic [31:0]            eoi_data,
  input  logic [NUM_SRC*8-1:0]   prio_flat,
  input  logic [NUM_SRC-1:0]     src_enable,
  input  logic [NUM_SRC-1:0]     src_level,
  input  logic [NUM_SRC-1:0]     src_line,
  input  logic [NUM_SRC-1:0]     src_target,
  input  logic [NUM_SRC-1:0]     src_one_of_n,
  output logic                   clr_valid,
  output logic [9:0]             clr_id,
  output logic                   clr_all,
  output logic                   set_valid,
  output logic [9:0]             set_id,
  output logic [9:0]             running_id,
  output logic [8:0]             running_prio,
  output logic                   busy
);
  localparam int unsigned AW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  function automatic src_prio_t prio_at(input irq_id_t id);
    if (id_in_range(id, NUM_SRC)) return prio_flat[{id[AW-1:0], 3'b000} +: PRIO_W];
    return '1;
  endfunction

  function automatic logic one_of_n_at(input irq_id_t id);
    if (id_in_range(id, NUM_SRC)) return src_one_of_n[id[AW-1:0]];
    return 1'b0;
  endfunction

  // named internal events
  irq_id_t   eoi_id, pred_of_running, walk_cur, walk_tgt, cur_link, tgt_link;
  irq_id_t   walk_wr_addr, walk_wr_data, mem_waddr, mem_wdata;
  src_prio_t hp_prio;
  run_prio_t restore_prio;
  logic      ack_take, ack_grant, eoi_take, eoi_ok, eoi_on_running, eoi_unlink;
  logic      repend, repend_fire, walk_wr_en, walk_hit, walk_end, mem_we;
  logic [2:0][ID_W-1:0] rd_addr, rd_data;

  assign eoi_id         = eoi_field(eoi_data);
  assign hp_prio        = prio_at(hp_id);
  assign ack_take       = ack_req && !busy;
  assign ack_grant      = ack_take && id_in_range(hp_id, NUM_SRC) &&
                          can_preempt(hp_prio, running_prio);
  assign eoi_take       = eoi_req && !busy && !ack_req;
  assign eoi_ok         = eoi_take && id_in_range(eoi_id, NUM_SRC) && (running_id != NO_IRQ);
  assign eoi_on_running = eoi_ok && (eoi_id == running_id);
  assign eoi_unlink     = eoi_ok && (eoi_id != running_id);
  assign repend_fire    = eoi_ok && repend;

  assign pred_of_running = rd_data[0];
  assign cur_link        = rd_data[1];
  assign tgt_link        = rd_data[2];
  assign rd_addr[0]      = running_id;
  assign rd_addr[1]      = walk_cur;
  assign rd_addr[2]      = walk_tgt;
  assign restore_prio    = (pred_of_running == NO_IRQ) ? IDLE_PRIO
                                                       : {1'b0, prio_at(pred_of_running)};

  // ack pushes and walk rewrites never coincide: ack is blocked while busy
  assign mem_we    = ack_grant || walk_wr_en;
  assign mem_waddr = ack_grant ? hp_id      : walk_wr_addr;
  assign mem_wdata = ack_grant ? running_id : walk_wr_data;

  irq_ack_link_mem #(.DEPTH(NUM_SRC), .NRD(3)) u_links (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  irq_ack_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(eoi_unlink), .start_id(running_id),
    .victim_id(eoi_id), .cur_id(walk_cur), .tgt_id(walk_tgt),
    .cur_link(cur_link), .tgt_link(tgt_link), .wr_en(walk_wr_en),
    .wr_addr(walk_wr_addr), .wr_data(walk_wr_data), .busy(busy),
    .walk_hit(walk_hit), .walk_end(walk_end)
  );

  irq_ack_repend #(.NUM_SRC(NUM_SRC)) u_repend (
    .id(eoi_id), .src_enable(src_enable), .src_level(src_level),
    .src_line(src_line), .src_target(src_target), .repend(repend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_id   <= NO_IRQ;
      running_prio <= IDLE_PRIO;
      ack_valid    <= 1'b0;
      ack_id       <= NO_IRQ;
      clr_valid    <= 1'b0;
      clr_id       <= NO_IRQ;
      clr_all      <= 1'b0;
      set_valid    <= 1'b0;
      set_id       <= NO_IRQ;
    end else begin
      ack_valid <= ack_take;
      ack_id    <= ack_grant ? hp_id : NO_IRQ;
      clr_valid <= ack_grant;
      clr_id    <= ack_grant ? hp_id : NO_IRQ;
      clr_all   <= ack_grant && one_of_n_at(hp_id);
      set_valid <= repend_fire;
      set_id    <= repend_fire ? eoi_id : NO_IRQ;
      if (ack_grant) begin
        running_id   <= hp_id;
        running_prio <= {1'b0, hp_prio};
      end else if (eoi_on_running) begin
        running_id   <= pred_of_running;
        running_prio <= restore_prio;
      end
    end
  end
endmodule

// File: rtl/irq_ack_tracker_chk.sv
module irq_ack_tracker_chk
  import irq_ack_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ack_valid,
  input logic [9:0] ack_id,
  input logic       clr_valid,
  input logic [9:0] clr_id,
  input logic       set_valid,
  input logic [9:0] running_id,
  input logic [8:0] running_prio,
  input logic       busy,
  input logic       walk_hit,
  input logic       walk_end
);
  // R1: a refused acknowledge leaves the running state alone
  a_r1_refusal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id == NO_IRQ) |-> (running_id == $past(running_id) &&
                                         running_prio == $past(running_prio)));

  // R2: a granted ID is the running one, with a real priority
  a_r2_grant_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id != NO_IRQ) |-> (running_id == ack_id && !running_prio[8]));

  // R3: idle means priority 0x100
  a_r3_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (running_id == NO_IRQ) |-> (running_prio == IDLE_PRIO));

  // R4: pending clear accompanies exactly a granted acknowledge
  a_r4_clear_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (ack_valid && clr_id == ack_id && ack_id != NO_IRQ));

  // R5: no re-pend without an interrupt running at the time of the write
  a_r5_no_repend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> ($past(running_id) != NO_IRQ));

  // R7: the walk never moves the running interrupt
  a_r7_walk_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (running_id == $past(running_id)));

  // R10: no acknowledge is served out of a busy cycle
  a_r10_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ack_valid);

  // R10: walk events only occur while busy and are exclusive
  a_r10_walk_events: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_hit || walk_end) |-> (busy && !(walk_hit && walk_end)));
endmodule

bind irq_ack_tracker irq_ack_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_id(ack_id),
  .clr_valid(clr_valid), .clr_id(clr_id), .set_valid(set_valid),
  .running_id(running_id), .running_prio(running_prio), .busy(busy),
  .walk_hit(walk_hit), .walk_end(walk_end)
);

// File: tb/sim_irq_ack_tracker.sv
module sim_irq_ack_tracker;
  localparam int NSRC = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ack_req = 1'b0;
  logic [9:0]      hp_id = 10'h3FF;
  logic            ack_valid;
  logic [9:0]      ack_id;
  logic            eoi_req = 1'b0;
  logic [31:0]     eoi_data = '0;
  logic [NSRC*8-1:0] prio_flat = '1;
  logic [NSRC-1:0] src_enable = '0, src_level = '0, src_line = '0;
  logic [NSRC-1:0] src_target = '0, src_one_of_n = '0;
  logic            clr_valid, clr_all, set_valid, busy;
  logic [9:0]      clr_id, set_id, running_id;
  logic [8:0]      running_prio;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  irq_ack_tracker #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_req(eoi_req), .eoi_data(eoi_data),
    .prio_flat(prio_flat), .src_enable(src_enable), .src_level(src_level),
    .src_line(src_line), .src_target(src_target), .src_one_of_n(src_one_of_n),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all),
    .set_valid(set_valid), .set_id(set_id), .running_id(running_id),
    .running_prio(running_prio), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every acknowledge response must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected ack response", ack_id, -1);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(ack_id == e, "R1/R2 ack response", ack_id, e);
      end
    end
  end

  task automatic set_prio(input int id, input logic [7:0] p);
    prio_flat[id*8 +: 8] = p;
  endtask

  // driver: one-cycle acknowledge, expectation pushed into the scoreboard
  task automatic do_ack(input logic [9:0] id, input logic [9:0] exp);
    @(negedge clk);
    ack_req = 1'b1;
    hp_id   = id;
    exp_q.push_back(exp);
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic do_eoi(input logic [31:0] data);
    @(negedge clk);
    eoi_req  = 1'b1;
    eoi_data = data;
    @(negedge clk);
    eoi_req = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_run(input string req, input int id, input int pr);
    check(running_id == id, req, running_id, id);
    check(running_prio == pr, req, running_prio, pr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int nb;
    set_prio(3, 8'hFF); set_prio(5, 8'h80); set_prio(7, 8'h40);
    set_prio(9, 8'h20); set_prio(10, 8'h80); set_prio(11, 8'h00);
    src_one_of_n[3] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    check_run("R3 reset state", 1023, 9'h100);
    check(!busy && !ack_valid && !clr_valid && !set_valid, "R3 reset outputs", busy, 0);

    // R1: nothing pending
    do_ack(10'h3FF, 10'h3FF);
    check_run("R1 no pending keeps idle", 1023, 9'h100);
    check(!clr_valid, "R1 no clear on refusal", clr_valid, 0);

    // R3/R4: 0xFF beats idle, 1-of-N clear for all
    do_ack(10'd3, 10'd3);
    check_run("R3 0xFF granted from idle", 3, 8'hFF);
    check(clr_valid && clr_id == 10'd3, "R4 clear id", clr_id, 3);
    check(clr_all == 1'b1, "R4 one-of-n clears all", clr_all, 1);

    // R2/R4: nested grant, clear for this processor only
    do_ack(10'd5, 10'd5);
    check_run("R2 nested grant", 5, 8'h80);
    check(clr_valid && clr_all == 1'b0, "R4 per-processor clear", clr_all, 0);

    // R1: equal priority is refused
    do_ack(10'd10, 10'h3FF);
    check_run("R1 equal priority refused", 5, 8'h80);

    do_ack(10'd7, 10'd7);
    do_ack(10'd9, 10'd9);
    check_run("R2 chain 9-7-5-3", 9, 8'h20);

    // R9/R7/R10: complete 7 via upper-bit garbage, ack during walk dropped
    do_eoi(32'hFFFF_FC07);
    check(busy == 1'b1, "R10 walk started", busy, 1);
    ack_req = 1'b1; hp_id = 10'd11;
    @(negedge clk);
    ack_req = 1'b0;
    check(!ack_valid, "R10 ack dropped while busy", ack_valid, 0);
    check(!busy, "R10 one-link walk length", busy, 0);
    check_run("R7 running kept after unlink", 9, 8'h20);

    // R6/R7: completing 9 restores 5 (7 was unlinked)
    do_eoi(32'd9);
    check_run("R7 R6 restore skips unlinked", 5, 8'h80);

    // R5: out-of-range and 1023 ignored
    do_eoi(32'd1023);
    check_run("R5 1023 ignored", 5, 8'h80);
    do_eoi(32'd100);
    check_run("R5 out of range ignored", 5, 8'h80);
    check(!busy, "R5 no walk on ignored write", busy, 0);

    // R10: deep walk, three links to reach 3
    do_ack(10'd7, 10'd7);
    do_ack(10'd9, 10'd9);
    do_eoi(32'd3);
    count_busy(nb);
    check(nb == 3, "R10 three-link walk", nb, 3);
    check_run("R7 deep unlink keeps running", 9, 8'h20);

    // R10: absent ID walks to the end, three links
    do_eoi(32'd12);
    count_busy(nb);
    check(nb == 3, "R10 walk to chain end", nb, 3);
    check_run("R7 absent id keeps running", 9, 8'h20);

    // R8: level re-pend rules
    src_level[9] = 1'b1; src_enable[9] = 1'b1; src_line[9] = 1'b1; src_target[9] = 1'b1;
    src_level[7] = 1'b0; src_enable[7] = 1'b1; src_line[7] = 1'b1; src_target[7] = 1'b1;
    src_level[5] = 1'b1; src_enable[5] = 1'b1; src_line[5] = 1'b1; src_target[5] = 1'b1;
    do_eoi(32'd9);
    check(set_valid && set_id == 10'd9, "R8 level source re-pended", set_id, 9);
    check_run("R6 restore 7", 7, 8'h40);
    do_eoi(32'd7);
    check(!set_valid, "R8 edge source not re-pended", set_valid, 0);
    check_run("R6 restore 5", 5, 8'h80);
    do_eoi(32'd5);
    check(set_valid && set_id == 10'd5, "R8 last level re-pend", set_id, 5);
    check_run("R6 restore idle 0x100", 1023, 9'h100);

    // R5: completion while idle ignored even for a high level source
    do_eoi(32'd5);
    check(!set_valid, "R5 idle completion no re-pend", set_valid, 0);
    check_run("R5 idle completion no change", 1023, 9'h100);

    // R3: priority 0 from idle
    do_ack(10'd11, 10'd11);
    check_run("R3 priority 0 granted", 11, 0);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule